// File: doc/BRIEF.md
# Correlator Access Recovery Stall

This block sits on a 16-bit processor bus in front of a correlator peripheral. It makes the processor wait until the correlator has recovered before the next correlator access. The correlator needs a minimum recovery time after any write that starts one of its internal write cycles. The block watches four things on the bus: the correlator chip select, the write strobe, the read strobe and the word address. It drives one stall output that holds off the next correlator access until that time has passed.

The recovery time is counted in clock cycles. A countdown loads when the write strobe of a qualifying correlator write falls, and then runs down to zero. The countdown keeps running while the processor is idle or busy on other peripherals, so that time counts toward recovery. A write to the staging high-half increment register does not start an internal cycle. Such a write leaves the countdown alone. Reads never load the countdown.

The bus has no data path and no valid/ready pair. All pins are plain control pins. Back-pressure takes one form only: while the stall output is high, the processor must keep its strobe, select and address steady. A stalled write completes when the processor drops its write strobe after the stall clears. A stalled read starts in the first cycle the stall is low.

Top module: `cws_gate`

## Requirements
- R1: `cor_wait` is high only in a cycle where `cor_sel` is high, `bus_wr` or `bus_rd` is high, and the recovery countdown is non-zero. It responds combinationally in that same cycle.
- R2: A correlator write completes when `bus_wr` falls. If the write was not to the staging high-half address, it loads the countdown with REC_CYC = ceil(RECOVERY_PS / CLK_PERIOD_PS) on that clock edge. The default is 32 cycles at 10 ns.
- R3: A completed correlator write to the staging high-half address (default 0x3C) leaves the countdown unchanged.
- R4: Reads never load the countdown. A read followed by any access is not stalled by that read.
- R5: An access with `cor_sel` low is never stalled and never changes the countdown.
- R6: After a load, a correlator access issued in the next cycle is stalled for exactly REC_CYC cycles.
- R7: Idle or non-correlator cycles count toward recovery. After a gap of g idle cycles (g < REC_CYC), the next correlator access stalls for REC_CYC - g cycles. With a gap of 40 cycles (400 ns) it does not stall at all.
- R8: A write to a low-half increment address (default 0x10, 0x11, 0x20, 0x21) that follows a staging high-half write loads the countdown.
- R9: Synchronous active-low reset clears the countdown, so the first correlator access after reset is not stalled.
- R10: A correlator write that arrives while the countdown is running is held until the countdown reaches zero. When it completes, it loads a fresh countdown.
- R11: A correlator read that arrives while the countdown is running is held and does not start until the countdown reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cor_sel | input | 1 | Chip select targeting the correlator |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_addr | input | ADDR_W | Word address of the access |
| cor_wait | output | 1 | Stall: hold the current correlator access |

## Verification
The hardest case to reach from the ports is a partial recovery: an access that lands part-way through a countdown after a chosen number of idle cycles. The stall length then has to match the remaining count exactly. The stimulus reaches it in two ways. Directed sequences place idle gaps of 20 and 40 cycles after a write. Seeded random traffic then mixes correlator and other accesses, high-half, low-half and other addresses, and gaps from 0 to 45 cycles. A bench model of the countdown predicts the stall level in every cycle.

// File: rtl/cws_pkg.sv
package cws_pkg;

  typedef enum logic [1:0] {
    WC_STAGE_HI = 2'd0,
    WC_PAIR_LO  = 2'd1,
    WC_OTHER    = 2'd2
  } wr_class_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/cws_strobe_track.sv
// Tracks the write strobe and remembers the target of the write in flight,
// so that completion (strobe fall) can be attributed to the right address.
module cws_strobe_track #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_done,
  output logic [ADDR_W-1:0] done_addr
);

  logic              wr_q;
  logic              cap_sel;
  logic [ADDR_W-1:0] cap_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      cap_sel  <= 1'b0;
      cap_addr <= '0;
    end else begin
      wr_q <= wr;
      if (wr) begin
        cap_sel  <= sel;
        cap_addr <= addr;
      end
    end
  end

  // completion of a correlator write: strobe was high, now low
  assign wr_done   = wr_q & ~wr & cap_sel;
  assign done_addr = cap_addr;

endmodule

// File: rtl/cws_addr_class.sv
// Classifies a completed write address: staging high half, paired low half,
// or any other register.
module cws_addr_class
  import cws_pkg::*;
#(
  parameter int unsigned              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0]        HI_ADDR = 8'h3C,
  parameter int unsigned              NUM_LO  = 4,
  parameter logic [NUM_LO*ADDR_W-1:0] LO_LIST = {8'h21, 8'h20, 8'h11, 8'h10}
) (
  input  logic [ADDR_W-1:0] addr,
  output wr_class_e         cls
);

  logic [NUM_LO-1:0] lo_hit;

  for (genvar gi = 0; gi < NUM_LO; gi++) begin : g_lo
    assign lo_hit[gi] = (addr == LO_LIST[gi*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    if (addr == HI_ADDR)  cls = WC_STAGE_HI;
    else if (|lo_hit)     cls = WC_PAIR_LO;
    else                  cls = WC_OTHER;
  end

endmodule

// File: rtl/cws_recovery.sv
// Recovery countdown: loads to full on request, otherwise runs down to zero.
module cws_recovery #(
  parameter int unsigned REC_CYC = 32,
  parameter int unsigned CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(REC_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= FULL;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/cws_gate.sv
module cws_gate
  import cws_pkg::*;
#(
  parameter int unsigned              CLK_PERIOD_PS = 10000,
  parameter int unsigned              RECOVERY_PS   = 314000,
  parameter int unsigned              ADDR_W        = 8,
  parameter logic [ADDR_W-1:0]        HI_ADDR       = 8'h3C,
  parameter int unsigned              NUM_LO        = 4,
  parameter logic [NUM_LO*ADDR_W-1:0] LO_LIST       = {8'h21, 8'h20, 8'h11, 8'h10}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cor_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              cor_wait
);

  localparam int unsigned REC_RAW = ceil_div(RECOVERY_PS, CLK_PERIOD_PS);
  localparam int unsigned REC_CYC = (REC_RAW == 0) ? 1 : REC_RAW;
  localparam int unsigned CNT_W   = $clog2(REC_CYC + 1);

  logic              wr_done;
  logic [ADDR_W-1:0] done_addr;
  wr_class_e         done_cls;
  logic              wr_load;
  logic [CNT_W-1:0]  rec_cnt;
  logic              rec_busy;
  logic              cor_req;

  cws_strobe_track #(.ADDR_W(ADDR_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (cor_sel),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wr_done   (wr_done),
    .done_addr (done_addr)
  );

  cws_addr_class #(
    .ADDR_W  (ADDR_W),
    .HI_ADDR (HI_ADDR),
    .NUM_LO  (NUM_LO),
    .LO_LIST (LO_LIST)
  ) u_class (
    .addr (done_addr),
    .cls  (done_cls)
  );

  // staging high-half writes start no internal cycle
  assign wr_load = wr_done && (done_cls != WC_STAGE_HI);

  cws_recovery #(.REC_CYC(REC_CYC), .CNT_W(CNT_W)) u_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_load),
    .cnt   (rec_cnt),
    .busy  (rec_busy)
  );

  assign cor_req  = cor_sel && (bus_wr || bus_rd);
  assign cor_wait = cor_req && rec_busy;

endmodule

// File: rtl/cws_gate_chk.sv
module cws_gate_chk #(
  parameter int unsigned       REC_CYC = 32,
  parameter int unsigned       CNT_W   = 6,
  parameter int unsigned       ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h3C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cor_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              cor_wait,
  input logic              wr_load,
  input logic [ADDR_W-1:0] done_addr,
  input logic [CNT_W-1:0]  rec_cnt
);

  a_r1_wait_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    cor_wait |-> (cor_sel && (bus_wr || bus_rd)));

  a_r5_unselected_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
    !cor_sel |-> !cor_wait);

  a_r3_stage_hi_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |-> (done_addr != HI_ADDR));

  a_r2_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (rec_cnt == CNT_W'(REC_CYC)));

  a_r6_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_cnt != '0 && !wr_load) |=> (rec_cnt == $past(rec_cnt) - 1'b1));

  a_r1_busy_request_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_sel && bus_rd && rec_cnt != '0) |-> cor_wait);

endmodule

bind cws_gate cws_gate_chk #(
  .REC_CYC (REC_CYC),
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W),
  .HI_ADDR (HI_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cor_sel   (cor_sel),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .cor_wait  (cor_wait),
  .wr_load   (wr_load),
  .done_addr (done_addr),
  .rec_cnt   (rec_cnt)
);

// File: tb/cws_gate_tb_top.sv
`timescale 1ns/1ps
module cws_gate_tb_top;

  localparam int REC = 32;
  localparam logic [7:0] HI = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cor_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       cor_wait;

  int total = 0;
  int bad = 0;
  int mcnt = 0;
  bit pend_load = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cws_gate dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cor_sel  (cor_sel),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .cor_wait (cor_wait)
  );

  // reference countdown built from the requirements (R2, R6, R7, R9)
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      mcnt = 0;
      pend_load = 1'b0;
    end else if (pend_load) begin
      mcnt = REC;
      pend_load = 1'b0;
    end else if (mcnt > 0) begin
      mcnt = mcnt - 1;
    end
  end

  function automatic bit exp_wait(input bit s, input bit req, input int c);
    return s && req && (c != 0);
  endfunction

  function automatic bit loads(input bit s, input bit w, input logic [7:0] a);
    return s && w && (a != HI);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // drives one access, holds it while stalled, then drops the strobe
  task automatic access(input bit s, input bit w, input logic [7:0] a,
                        input string req, output int waits);
    waits = 0;
    @(negedge clk);
    cor_sel = s; bus_wr = w; bus_rd = !w; bus_addr = a;
    forever begin
      #1;
      chk(cor_wait == exp_wait(s, 1'b1, mcnt), req, cor_wait, exp_wait(s, 1'b1, mcnt));
      if (!cor_wait) break;
      waits++;
      @(negedge clk);
    end
    @(negedge clk);
    if (loads(s, w, a)) pend_load = 1'b1;
    cor_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    #1;
    chk(cor_wait == 1'b0, req, cor_wait, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cor_wait == 1'b0, "R9 reset", cor_wait, 0);
    access(1, 0, 8'h10, "R9 first read", w);
    chk(w == 0, "R9 first access", w, 0);

    // R2, R6, R11: low-half write then immediate read stalls REC cycles
    access(1, 1, 8'h10, "R2 write", w);
    chk(w == 0, "R2 write unstalled", w, 0);
    access(1, 0, 8'h05, "R11 read", w);
    chk(w == REC, "R6 full stall", w, REC);

    // R3: staging high write loads nothing
    access(1, 1, HI, "R3 hi write", w);
    access(1, 0, 8'h05, "R3 read", w);
    chk(w == 0, "R3 no stall after hi", w, 0);

    // R8 and R10: low-half after high loads; next write is held and reloads
    access(1, 1, HI, "R8 hi", w);
    access(1, 1, 8'h11, "R8 lo", w);
    access(1, 1, 8'h05, "R10 held write", w);
    chk(w == REC, "R8 pair load", w, REC);
    access(1, 0, 8'h07, "R10 reload", w);
    chk(w == REC, "R10 reload", w, REC);

    // R4: reads do not load
    access(1, 0, 8'h20, "R4 read", w);
    access(1, 0, 8'h21, "R4 read2", w);
    chk(w == 0, "R4 read no load", w, 0);

    // R5: unselected accesses neither stall nor load
    access(1, 1, 8'h20, "R5 load", w);
    access(0, 0, 8'h20, "R5 other read", w);
    chk(w == 0, "R5 unselected unstalled", w, 0);
    idle(REC);
    access(0, 1, 8'h11, "R5 other write", w);
    access(1, 0, 8'h11, "R5 read after", w);
    chk(w == 0, "R5 no load", w, 0);

    // R7: idle credit
    access(1, 1, 8'h21, "R7 write", w);
    idle(20);
    access(1, 0, 8'h21, "R7 partial", w);
    chk(w == REC - 20, "R7 partial", w, REC - 20);
    access(1, 1, 8'h21, "R7 write2", w);
    idle(40);
    access(1, 0, 8'h21, "R7 400ns", w);
    chk(w == 0, "R7 400ns gap", w, 0);

    // R9: reset mid countdown
    access(1, 1, 8'h10, "R9 write", w);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    access(1, 0, 8'h10, "R9 after reset", w);
    chk(w == 0, "R9 cleared", w, 0);

    // random traffic against the model (R1, R2, R3, R5, R7, R10, R11)
    void'($urandom(32'd2024));
    for (int k = 0; k < 400; k++) begin
      bit s, wr_b;
      logic [7:0] a;
      int pick;
      s = ($urandom % 4) != 0;
      wr_b = $urandom % 2;
      pick = $urandom % 4;
      a = (pick == 0) ? HI : (pick == 1) ? 8'h10 : (pick == 2) ? 8'h21 : 8'($urandom);
      access(s, wr_b, a, "R1 random", w);
      idle($urandom % 46);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule